// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for each beat of one SDRAM read or write burst. A controller issues a start pulse with the first column, a length code and a burst-order flag; from the next clock on, the block offers one column per clock in which the advance input is high. It marks the final beat of a bounded burst and drops back to idle after it. A stop input ends any burst at once, and is the only way to end a full-page burst.

Two orders are provided for bounded bursts. In the linear order the low bits of the column count upward and wrap inside the block aligned to the burst length, while the upper bits keep their start value. In the interleaved order the low bits are the start column XORed with the beat number. The full-page mode walks the whole 256-column row upward, wrapping from 255 to 0, until it is stopped. Length, order and start column are all captured when the burst starts.

The controller is a three-state machine. IDLE waits for a start pulse. Start moves it to RUN_BOUNDED for lengths 1, 2, 4 and 8, or to RUN_FULLPAGE when the length code selects full page. RUN_BOUNDED returns to IDLE when its final beat is issued or when stop is high. RUN_FULLPAGE returns to IDLE only when stop is high. No other transitions exist.

Top module: `sdram_burst_colgen`

## Requirements
- R1: During and right after reset, busy_o, beat_o and last_o are low.
- R2: A start_i pulse while idle captures start_col_i. On the next clock busy_o is high and col_o equals the captured column. beat_o is then high in any cycle in which advance_i is high and stop_i is low.
- R3: The length code len_code_i selects 1, 2, 4 or 8 beats for the values 0, 1, 2 and 3. Any value with bit 2 set selects full page.
- R4: In the linear order (ilv_i = 0), beat k carries the start column with its low log2(length) bits replaced by (start low bits + k) modulo the length. The upper bits are unchanged.
- R5: In the interleaved order (ilv_i = 1), beat k carries the start column XORed with k. Only the low log2(length) bits change.
- R6: In full-page mode beat k carries (start + k) modulo 256. ilv_i is ignored, last_o never rises, and the burst continues until stop_i.
- R7: last_o is high together with beat_o on beat number length-1 of a bounded burst, and busy_o is low on the next clock.
- R8: While busy, a cycle with advance_i low and stop_i low issues no beat. col_o keeps its value and the beat number does not move.
- R9: stop_i while busy suppresses beat_o in that same cycle, and busy_o is low on the next clock.
- R10: start_i while busy is ignored. The running burst's column sequence and length are unchanged.
- R11: Changes to start_col_i, len_code_i or ilv_i after the start cycle have no effect on the running burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a burst (acted on only when idle) |
| start_col_i | input | 8 | First column of the burst |
| len_code_i | input | 3 | Length code: 0..3 give 1/2/4/8 beats, bit 2 set gives full page |
| ilv_i | input | 1 | 1 selects interleaved order for bounded bursts |
| advance_i | input | 1 | Issue a beat this cycle when busy |
| stop_i | input | 1 | End the burst now, with no beat this cycle |
| col_o | output | 8 | Column of the current beat |
| beat_o | output | 1 | A beat is issued this cycle |
| last_o | output | 1 | The issued beat is the final beat of a bounded burst |
| busy_o | output | 1 | A burst is in progress |

## Verification
A start pulse takes effect one clock later: busy_o and the first column appear after the next rising edge. beat_o and last_o respond in the same cycle to advance_i and stop_i, because they are combinational from those inputs and the registered state. The bench drives inputs on the falling edge and compares all four outputs one nanosecond later, against a behavioural model whose state is updated only at the rising edge. In this way same-cycle gating and next-cycle state changes are each checked in the cycle where they are due.

// File: rtl/sdram_burst_pkg.sv
package sdram_burst_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_BOUNDED   = 2'd1,
        ST_FULLPAGE  = 2'd2
    } burst_state_t;

    typedef struct packed {
        logic       full_page;
        logic       interleave;
    } burst_mode_t;

endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode #(
    parameter int COL_W  = 8,
    parameter int CODE_W = 3
) (
    input  logic [CODE_W-1:0] len_code_i,
    output logic [COL_W-1:0]  mask_o,
    output logic              full_page_o
);
    localparam int LOG_SEL_W = CODE_W - 1;

    assign full_page_o = len_code_i[CODE_W-1];

    // Bit i of the wrap mask is set when the burst spans more than 2^i columns.
    for (genvar i = 0; i < COL_W; i++) begin : g_mask
        assign mask_o[i] = full_page_o | (32'(len_code_i[LOG_SEL_W-1:0]) > i);
    end

endmodule

// File: rtl/burst_addr_map.sv
module burst_addr_map #(
    parameter int COL_W       = 8,
    parameter bit ILV_SUPPORT = 1'b1
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] beat_idx_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] sum;
    logic [COL_W-1:0] linear_col;

    assign sum        = base_i + beat_idx_i;
    assign linear_col = (base_i & ~mask_i) | (sum & mask_i);

    if (ILV_SUPPORT) begin : g_ilv
        logic [COL_W-1:0] xor_col;
        assign xor_col = base_i ^ (beat_idx_i & mask_i);
        assign col_o   = ilv_i ? xor_col : linear_col;
    end else begin : g_lin_only
        logic unused_ilv;
        assign unused_ilv = ilv_i;
        assign col_o      = linear_col;
    end

endmodule

// File: rtl/burst_seq_fsm.sv
module burst_seq_fsm
    import sdram_burst_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             advance_i,
    input  logic             stop_i,
    input  logic             dec_full_i,
    input  logic [COL_W-1:0] run_mask_i,
    output logic [COL_W-1:0] beat_idx_o,
    output logic             load_o,
    output logic             beat_o,
    output logic             last_o,
    output logic             busy_o
);
    burst_state_t     state_q, state_d;
    logic [COL_W-1:0] idx_q, idx_d;
    logic             final_beat;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // Outputs and next state
    always_comb begin
        state_d    = state_q;
        idx_d      = idx_q;
        load_o     = 1'b0;
        beat_o     = 1'b0;
        last_o     = 1'b0;
        busy_o     = 1'b0;
        final_beat = (idx_q == run_mask_i);
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    load_o  = 1'b1;
                    idx_d   = '0;
                    state_d = dec_full_i ? ST_FULLPAGE : ST_BOUNDED;
                end
            end
            ST_BOUNDED: begin
                busy_o = 1'b1;
                if (stop_i) begin
                    state_d = ST_IDLE;
                end else if (advance_i) begin
                    beat_o = 1'b1;
                    if (final_beat) begin
                        last_o  = 1'b1;
                        state_d = ST_IDLE;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
            end
            ST_FULLPAGE: begin
                busy_o = 1'b1;
                if (stop_i) begin
                    state_d = ST_IDLE;
                end else if (advance_i) begin
                    beat_o = 1'b1;
                    idx_d  = idx_q + 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    assign beat_idx_o = idx_q;

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
    import sdram_burst_pkg::*;
#(
    parameter int COL_W  = 8,
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [COL_W-1:0]  start_col_i,
    input  logic [CODE_W-1:0] len_code_i,
    input  logic              ilv_i,
    input  logic              advance_i,
    input  logic              stop_i,
    output logic [COL_W-1:0]  col_o,
    output logic              beat_o,
    output logic              last_o,
    output logic              busy_o
);
    logic [COL_W-1:0] dec_mask;
    logic             dec_full;
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] mask_q;
    burst_mode_t      mode_q;
    logic [COL_W-1:0] beat_idx;
    logic             load;

    burst_len_decode #(.COL_W(COL_W), .CODE_W(CODE_W)) u_dec (
        .len_code_i (len_code_i),
        .mask_o     (dec_mask),
        .full_page_o(dec_full)
    );

    burst_seq_fsm #(.COL_W(COL_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .advance_i  (advance_i),
        .stop_i     (stop_i),
        .dec_full_i (dec_full),
        .run_mask_i (mask_q),
        .beat_idx_o (beat_idx),
        .load_o     (load),
        .beat_o     (beat_o),
        .last_o     (last_o),
        .busy_o     (busy_o)
    );

    // Burst configuration captured at start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            mask_q <= '0;
            mode_q <= '0;
        end else if (load) begin
            base_q            <= start_col_i;
            mask_q            <= dec_mask;
            mode_q.full_page  <= dec_full;
            mode_q.interleave <= ilv_i & ~dec_full;
        end
    end

    burst_addr_map #(.COL_W(COL_W), .ILV_SUPPORT(1'b1)) u_map (
        .base_i    (base_q),
        .beat_idx_i(beat_idx),
        .mask_i    (mask_q),
        .ilv_i     (mode_q.interleave),
        .col_o     (col_o)
    );

endmodule

// File: rtl/sdram_burst_colgen_chk.sv
module sdram_burst_colgen_chk #(
    parameter int COL_W  = 8,
    parameter int CODE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [COL_W-1:0]  start_col_i,
    input logic [CODE_W-1:0] len_code_i,
    input logic              advance_i,
    input logic              stop_i,
    input logic [COL_W-1:0]  col_o,
    input logic              beat_o,
    input logic              last_o,
    input logic              busy_o
);
    logic fp_run;

    always_ff @(posedge clk) begin
        if (!rst_n)                 fp_run <= 1'b0;
        else if (start_i && !busy_o) fp_run <= len_code_i[CODE_W-1];
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!beat_o && !last_o));

    assert_start_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && col_o == $past(start_col_i)));

    assert_fullpage_nolast_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && fp_run) |-> !last_o);

    assert_last_with_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> beat_o);

    assert_last_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> !busy_o);

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !advance_i && !stop_i) |=> (busy_o && $stable(col_o)));

    assert_stop_nobeat_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && stop_i) |-> !beat_o);

    assert_stop_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && stop_i) |=> !busy_o);

    assert_restart_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !stop_i && !last_o) |=> busy_o);

endmodule

bind sdram_burst_colgen sdram_burst_colgen_chk #(.COL_W(COL_W), .CODE_W(CODE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .start_col_i(start_col_i),
    .len_code_i (len_code_i),
    .advance_i  (advance_i),
    .stop_i     (stop_i),
    .col_o      (col_o),
    .beat_o     (beat_o),
    .last_o     (last_o),
    .busy_o     (busy_o)
);

// File: tb/tb_sdram_burst_colgen.sv
module tb_sdram_burst_colgen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] start_col_i = '0;
    logic [2:0] len_code_i = '0;
    logic       ilv_i = 1'b0;
    logic       advance_i = 1'b0;
    logic       stop_i = 1'b0;
    logic [7:0] col_o;
    logic       beat_o, last_o, busy_o;

    int n_checks = 0;
    int n_fail   = 0;

    // reference model state
    bit m_busy = 0;
    int m_base = 0, m_idx = 0, m_len = 0, m_ilv = 0;

    always #4 clk = ~clk;

    sdram_burst_colgen dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
        .len_code_i(len_code_i), .ilv_i(ilv_i), .advance_i(advance_i),
        .stop_i(stop_i), .col_o(col_o), .beat_o(beat_o), .last_o(last_o),
        .busy_o(busy_o)
    );

    task automatic chk(string tag, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic int exp_col();
        int lo;
        if (m_len == 0) return (m_base + m_idx) % 256;
        lo = m_base % m_len;
        if (m_ilv != 0) return (m_base - lo) + (lo ^ m_idx);
        return (m_base - lo) + ((lo + m_idx) % m_len);
    endfunction

    // One clock: drive on falling edge, compare, then advance the model at the rising edge.
    task automatic step(bit st, int scol, int code, bit ilv, bit adv, bit stp, string tag);
        bit e_beat, e_last;
        @(negedge clk);
        start_i = st; start_col_i = 8'(scol); len_code_i = 3'(code);
        ilv_i = ilv; advance_i = adv; stop_i = stp;
        #1;
        e_beat = m_busy && adv && !stp;
        e_last = e_beat && m_len != 0 && m_idx == m_len - 1;
        chk(tag, "busy", int'(busy_o), int'(m_busy));
        chk(tag, "beat", int'(beat_o), int'(e_beat));
        chk(tag, "last", int'(last_o), int'(e_last));
        if (m_busy) chk(tag, "col", int'(col_o), exp_col());
        @(posedge clk);
        if (!m_busy) begin
            if (st) begin
                m_busy = 1; m_base = scol; m_idx = 0;
                m_len  = (code >= 4) ? 0 : (1 << code);
                m_ilv  = (ilv && m_len != 0) ? 1 : 0;
            end
        end else if (stp) begin
            m_busy = 0;
        end else if (e_beat) begin
            if (e_last) m_busy = 0;
            else m_idx = (m_idx + 1) % 256;
        end
    endtask

    task automatic run_burst(int scol, int code, bit ilv, int beats, string tag);
        step(1, scol, code, ilv, 0, 0, tag);
        for (int i = 0; i < beats; i++) step(0, scol, code, ilv, 1, 0, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "busy in reset", int'(busy_o), 0);
        chk("R1", "beat in reset", int'(beat_o), 0);
        chk("R1", "last in reset", int'(last_o), 0);
        rst_n = 1'b1;
        step(0, 0, 0, 0, 1, 0, "R1");

        // R2/R4: linear length 4 from 0x2D -> 2D 2E 2F 2C
        run_burst(8'h2D, 2, 0, 5, "R4");
        // R5: interleaved length 8 from 0x15
        run_burst(8'h15, 3, 1, 9, "R5");
        // R3: lengths 1 and 2, both orders
        run_burst(8'h40, 0, 0, 2, "R3");
        run_burst(8'h33, 1, 0, 3, "R3");
        run_burst(8'h33, 1, 1, 3, "R3");
        run_burst(8'h7E, 3, 0, 9, "R4");
        run_burst(8'h07, 2, 1, 5, "R5");

        // R7: last beat then idle, immediate restart
        run_burst(8'h10, 1, 0, 2, "R7");
        run_burst(8'h11, 1, 0, 3, "R7");

        // R8: gaps in advance
        step(1, 8'hA5, 3, 0, 0, 0, "R8");
        for (int i = 0; i < 16; i++) step(0, 8'hA5, 3, 0, (i % 3) != 0, 0, "R8");

        // R9: stop in the middle of a bounded burst, then quiet cycles
        step(1, 8'h20, 3, 0, 0, 0, "R9");
        step(0, 8'h20, 3, 0, 1, 0, "R9");
        step(0, 8'h20, 3, 0, 1, 0, "R9");
        step(0, 8'h20, 3, 0, 1, 1, "R9");
        step(0, 8'h20, 3, 0, 1, 0, "R9");
        step(0, 8'h20, 3, 0, 1, 0, "R9");

        // R10/R11: restart attempts and input changes mid burst
        step(1, 8'h58, 2, 1, 0, 0, "R10");
        step(1, 8'h03, 7, 0, 1, 0, "R10");
        step(1, 8'hFF, 0, 0, 1, 0, "R11");
        step(0, 8'h81, 4, 0, 1, 0, "R11");
        step(0, 8'h81, 1, 0, 1, 0, "R11");
        step(0, 8'h81, 1, 0, 1, 0, "R11");

        // R6: full page from 0xFA with interleave requested, wraps past 255 and idx 256
        step(1, 8'hFA, 4, 1, 0, 0, "R6");
        for (int i = 0; i < 300; i++) step(0, 8'hFA, 4, 1, (i % 7) != 3, 0, "R6");
        step(0, 8'hFA, 4, 1, 1, 1, "R6");
        step(0, 8'hFA, 4, 1, 1, 0, "R6");
        chk("R6", "busy after stop", int'(busy_o), 0);

        // R6/R3: code 7 also full page
        step(1, 8'h02, 7, 0, 0, 0, "R3");
        for (int i = 0; i < 20; i++) step(0, 8'h02, 7, 0, 1, 0, "R3");
        step(0, 8'h02, 7, 0, 0, 1, "R9");
        step(0, 8'h00, 0, 0, 1, 0, "R9");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule